// File: doc/BRIEF.md
# Interleaved Memory Decoder Target Lookup

This block maps a physical request address to the downstream port that serves it. It holds a small set of address-window decoders. Each decoder has a base, a size, a control word and a list of eight port numbers. A lookup scans the decoders from the lowest index upward. The first window that contains the address decides the outcome. If that decoder is committed and its encodings are legal, an interleave index is taken from the address. That index selects one byte of the port list.

Decoder state is loaded through a one-word-per-cycle configuration write port. A capability word sets how many decoders take part in the search. A lookup is presented with a valid strobe. One clock later the block returns a found flag and the 8-bit port number. A miss returns zero in both.

Top module: `ildec_lookup`

## Requirements
- R1: A decoder's base is formed as {base_hi word, bits 31:28 of the base_lo word, 28 zero bits}, and its size is formed the same way from size_hi and size_lo. Bits 27:0 of either low word have no effect on any lookup.
- R2: An address hits a decoder only when base <= address < base + size, with the sum computed without overflow. A decoder of size zero never hits.
- R3: Decoders are searched from index 0 upward. The first active decoder whose window holds the address decides the result, even when a later decoder also holds it.
- R4: The control word's committed flag is bit 8. When the deciding decoder has it clear, the lookup reports a miss and no later decoder is consulted.
- R5: The control word holds the granularity code in bits 3:0 and the ways code in bits 7:4. The interleave index is (address / (256 << granularity code)) mod (2 ** ways code). A granularity code above 6 or a ways code above 3 on the deciding decoder gives a miss.
- R6: The port list is 64 bits, little-endian, formed from two words. Indices 0 to 3 select byte index*8 of the target_lo word, and indices 4 to 7 select byte (index-4)*8 of the target_hi word.
- R7: Capability bits 3:0 hold a count code: code 0 activates one decoder, and any other code activates 2*code decoders, capped at NUM_DEC. Decoders outside that count never hit.
- R8: rsp_valid is high exactly in the cycle after req_valid. rsp_found and rsp_port give the result for the address presented then, and both are 0 on a miss and whenever rsp_valid is low.
- R9: After reset, every decoder word and the capability word are zero, rsp_valid is low, and any lookup misses.
- R10: A configuration write takes effect for lookups issued in the next cycle. cfg_reg selects the word: 0 base_lo, 1 base_hi, 2 size_lo, 3 size_hi, 4 control, 5 target_lo, 6 target_hi, 7 capability (cfg_dec is ignored for code 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dec | input | SEL_W | Decoder index for the write |
| cfg_reg | input | 3 | Word select for the write |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 64 | Lookup address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_found | output | 1 | A committed decoder resolved the address |
| rsp_port | output | 8 | Selected port number, 0 on a miss |

## Verification
On every cycle, the assertions check the one-cycle response timing and the zeroed outputs on a miss or when idle. They also check that a request hitting no active window can never be found, and that a first hit on an uncommitted decoder or one with illegal encodings always reports a miss. The arithmetic can only be shown by the bench's scenarios, comparing results against its own model: the window bounds, the masking of the low 28 bits, priority among overlapping windows, the interleave index, the byte chosen from the port list, and the active-decoder count.

// File: rtl/ildec_pkg.sv
package ildec_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  localparam int PORT_W = 8;
  localparam int MAX_GRAN_ENC = 6;
  localparam int MAX_WAYS_ENC = 3;

  typedef enum logic [2:0] {
    REG_BASE_LO = 3'd0,
    REG_BASE_HI = 3'd1,
    REG_SIZE_LO = 3'd2,
    REG_SIZE_HI = 3'd3,
    REG_CTRL    = 3'd4,
    REG_TGT_LO  = 3'd5,
    REG_TGT_HI  = 3'd6,
    REG_CAP     = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] base_hi;
    logic [3:0]        base_top;
    logic [WORD_W-1:0] size_hi;
    logic [3:0]        size_top;
    logic              committed;
    logic [3:0]        ways_enc;
    logic [3:0]        gran_enc;
    logic [WORD_W-1:0] tgt_lo;
    logic [WORD_W-1:0] tgt_hi;
  } dec_entry_t;

  // Window edge from a high word and the four top bits of a low word.
  function automatic logic [ADDR_W-1:0] form_addr(input logic [WORD_W-1:0] hi,
                                                  input logic [3:0] top);
    return {hi, top, 28'b0};
  endfunction

  // Containment test widened by one bit so base + size cannot wrap.
  function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W-1:0] size);
    logic [ADDR_W:0] a_x, b_x, lim_x;
    a_x   = {1'b0, addr};
    b_x   = {1'b0, base};
    lim_x = {1'b0, base} + {1'b0, size};
    return (a_x >= b_x) && (a_x < lim_x);
  endfunction

  // Active decoder count from the capability code.
  function automatic logic [4:0] decode_count(input logic [3:0] enc);
    return (enc == 4'd0) ? 5'd1 : {enc, 1'b0};
  endfunction

  function automatic logic enc_legal(input logic [3:0] gran, input logic [3:0] ways);
    return (int'(gran) <= MAX_GRAN_ENC) && (int'(ways) <= MAX_WAYS_ENC);
  endfunction

  // Interleave index: shift out granule bits, keep ways_enc low bits.
  function automatic logic [2:0] interleave_idx(input logic [ADDR_W-1:0] addr,
                                                input logic [3:0] gran,
                                                input logic [3:0] ways);
    logic [ADDR_W-1:0] granule;
    logic [3:0]        mask;
    granule = addr >> (5'd8 + {1'b0, gran});
    mask    = (4'd1 << ways[1:0]) - 4'd1;
    return granule[2:0] & mask[2:0];
  endfunction

  // Byte select from a little-endian list split over two words.
  function automatic logic [PORT_W-1:0] pick_port(input logic [WORD_W-1:0] lo,
                                                  input logic [WORD_W-1:0] hi,
                                                  input logic [2:0] idx);
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] shifted;
    word    = idx[2] ? hi : lo;
    shifted = word >> {idx[1:0], 3'b000};
    return shifted[PORT_W-1:0];
  endfunction
endpackage

// File: rtl/ildec_table.sv
module ildec_table
  import ildec_pkg::*;
#(
  parameter int NUM_DEC = 4,
  parameter int SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_dec,
  input  logic [2:0]                cfg_reg,
  input  logic [WORD_W-1:0]         cfg_data,
  output dec_entry_t [NUM_DEC-1:0]  entries,
  output logic [3:0]                cap_enc
);
  logic dec_in_range;
  assign dec_in_range = int'(cfg_dec) < NUM_DEC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entries <= '0;
      cap_enc <= '0;
    end else if (cfg_we) begin
      if (reg_sel_e'(cfg_reg) == REG_CAP) begin
        cap_enc <= cfg_data[3:0];
      end else if (dec_in_range) begin
        case (reg_sel_e'(cfg_reg))
          REG_BASE_LO: entries[cfg_dec].base_top <= cfg_data[31:28];
          REG_BASE_HI: entries[cfg_dec].base_hi  <= cfg_data;
          REG_SIZE_LO: entries[cfg_dec].size_top <= cfg_data[31:28];
          REG_SIZE_HI: entries[cfg_dec].size_hi  <= cfg_data;
          REG_CTRL: begin
            entries[cfg_dec].gran_enc  <= cfg_data[3:0];
            entries[cfg_dec].ways_enc  <= cfg_data[7:4];
            entries[cfg_dec].committed <= cfg_data[8];
          end
          REG_TGT_LO:  entries[cfg_dec].tgt_lo <= cfg_data;
          REG_TGT_HI:  entries[cfg_dec].tgt_hi <= cfg_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ildec_match.sv
module ildec_match
  import ildec_pkg::*;
#(
  parameter int NUM_DEC = 4
) (
  input  dec_entry_t [NUM_DEC-1:0] entries,
  input  logic [3:0]               cap_enc,
  input  logic [ADDR_W-1:0]        addr,
  output logic [NUM_DEC-1:0]       hit_vec,
  output logic [NUM_DEC-1:0]       active_mask
);
  logic [4:0] active_cnt;
  assign active_cnt = decode_count(cap_enc);

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] size_w;
    assign base_w         = form_addr(entries[i].base_hi, entries[i].base_top);
    assign size_w         = form_addr(entries[i].size_hi, entries[i].size_top);
    assign hit_vec[i]     = in_window(addr, base_w, size_w);
    assign active_mask[i] = i < int'(active_cnt);
  end
endmodule

// File: rtl/ildec_pick.sv
module ildec_pick
  import ildec_pkg::*;
#(
  parameter int NUM_DEC = 4
) (
  input  dec_entry_t [NUM_DEC-1:0] entries,
  input  logic [NUM_DEC-1:0]       hit_vec,
  input  logic [NUM_DEC-1:0]       active_mask,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     sel_committed,
  output logic                     sel_legal,
  output logic [PORT_W-1:0]        sel_port
);
  dec_entry_t sel;
  logic       taken;

  always_comb begin
    sel   = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_DEC; i++) begin
      if (!taken && hit_vec[i] && active_mask[i]) begin
        sel   = entries[i];
        taken = 1'b1;
      end
    end
  end

  assign sel_committed = sel.committed;
  assign sel_legal     = enc_legal(sel.gran_enc, sel.ways_enc);
  assign sel_port      = pick_port(sel.tgt_lo, sel.tgt_hi,
                                   interleave_idx(addr, sel.gran_enc, sel.ways_enc));
endmodule

// File: rtl/ildec_lookup.sv
module ildec_lookup
  import ildec_pkg::*;
#(
  parameter int NUM_DEC = 4,
  localparam int SEL_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_dec,
  input  logic [2:0]         cfg_reg,
  input  logic [31:0]        cfg_data,
  input  logic               req_valid,
  input  logic [63:0]        req_addr,
  output logic               rsp_valid,
  output logic               rsp_found,
  output logic [7:0]         rsp_port
);
  dec_entry_t [NUM_DEC-1:0] entries;
  logic [3:0]               cap_enc;
  logic [NUM_DEC-1:0]       hit_vec;
  logic [NUM_DEC-1:0]       active_mask;
  logic                     win_hit;
  logic                     win_committed;
  logic                     win_legal;
  logic [PORT_W-1:0]        win_port;
  logic                     lookup_found;

  ildec_table #(.NUM_DEC(NUM_DEC), .SEL_W(SEL_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dec(cfg_dec),
    .cfg_reg(cfg_reg), .cfg_data(cfg_data), .entries(entries), .cap_enc(cap_enc)
  );

  ildec_match #(.NUM_DEC(NUM_DEC)) u_match (
    .entries(entries), .cap_enc(cap_enc), .addr(req_addr),
    .hit_vec(hit_vec), .active_mask(active_mask)
  );

  ildec_pick #(.NUM_DEC(NUM_DEC)) u_pick (
    .entries(entries), .hit_vec(hit_vec), .active_mask(active_mask),
    .addr(req_addr), .sel_committed(win_committed), .sel_legal(win_legal),
    .sel_port(win_port)
  );

  assign win_hit      = |(hit_vec & active_mask);
  assign lookup_found = win_hit & win_committed & win_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_port  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_found <= req_valid & lookup_found;
      rsp_port  <= (req_valid & lookup_found) ? win_port : '0;
    end
  end
endmodule

// File: rtl/ildec_chk.sv
module ildec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       rsp_valid,
  input logic       rsp_found,
  input logic [7:0] rsp_port,
  input logic       win_hit,
  input logic       win_committed,
  input logic       win_legal
);
  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_idle_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_found && rsp_port == 8'd0));

  assert_miss_port_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_found) |-> rsp_port == 8'd0);

  assert_no_window_no_find_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !win_hit) |=> !rsp_found);

  assert_uncommitted_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit && !win_committed) |=> !rsp_found);

  assert_illegal_enc_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit && !win_legal) |=> !rsp_found);
endmodule

bind ildec_lookup ildec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_found(rsp_found), .rsp_port(rsp_port), .win_hit(win_hit),
  .win_committed(win_committed), .win_legal(win_legal)
);

// File: tb/ildec_lookup_tb.sv
`timescale 1ns/1ps
module ildec_lookup_tb;
  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_dec = '0;
  logic [2:0]  cfg_reg = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_found;
  logic [7:0]  rsp_port;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_word [ND][7];
  logic [31:0] m_cap;

  always #4 clk = ~clk;

  ildec_lookup #(.NUM_DEC(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dec(cfg_dec), .cfg_reg(cfg_reg),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_port(rsp_port)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int dec, input int sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dec = 2'(dec); cfg_reg = 3'(sel); cfg_data = data;
    if (sel == 7) m_cap = data; else m_word[dec][sel] = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_dec(input int d, input logic [63:0] base, input logic [63:0] size,
                         input logic [31:0] ctrl, input logic [31:0] tlo,
                         input logic [31:0] thi);
    wr(d, 0, base[31:0]); wr(d, 1, base[63:32]);
    wr(d, 2, size[31:0]); wr(d, 3, size[63:32]);
    wr(d, 4, ctrl); wr(d, 5, tlo); wr(d, 6, thi);
  endtask

  function automatic logic [8:0] model(input logic [63:0] a);
    int cnt;
    cnt = (m_cap[3:0] == 0) ? 1 : 2 * int'(m_cap[3:0]);
    for (int i = 0; i < ND; i++) begin
      logic [63:0] b, s, gran, idx, list;
      int g, w;
      if (i >= cnt) return 9'd0;
      b = {m_word[i][1], 32'h0} + {32'h0, m_word[i][0] & 32'hF000_0000};
      s = {m_word[i][3], 32'h0} + {32'h0, m_word[i][2] & 32'hF000_0000};
      if (a >= b && (a - b) < s) begin
        g = int'(m_word[i][4][3:0]);
        w = int'(m_word[i][4][7:4]);
        if (!m_word[i][4][8] || g > 6 || w > 3) return 9'd0;
        gran = 64'd256 * (64'd1 << g);
        idx  = (a / gran) % (64'd1 << w);
        list = {m_word[i][6], m_word[i][5]};
        return {1'b1, 8'((list / (64'd1 << (idx * 8))) % 256)};
      end
    end
    return 9'd0;
  endfunction

  task automatic look(input string req, input logic [63:0] a);
    logic [8:0] e;
    e = model(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R8 valid"}, 64'(rsp_valid), 64'd1);
    check({req, " found"}, 64'(rsp_found), 64'(e[8]));
    check({req, " port"}, 64'(rsp_port), 64'(e[7:0]));
  endtask

  initial begin
    for (int i = 0; i < ND; i++) for (int j = 0; j < 7; j++) m_word[i][j] = '0;
    m_cap = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R9 reset rsp_found", 64'(rsp_found), 64'd0);
    rst_n = 1'b1;
    look("R9 empty table", 64'h0);
    @(negedge clk);
    check("R8 idle after response", 64'(rsp_valid), 64'd0);

    wr(0, 7, 32'h2); // R7: code 2 activates 4 decoders; R10 capability select
    set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 32'h120, 32'h4433_2211, 32'h8877_6655);
    for (int k = 0; k < 5; k++) look("R5 R6 ways4 gran256", 64'h1_0000_0000 + 64'(k) * 256);
    set_dec(1, 64'h1_1000_0000, 64'h2000_0000, 32'h132, 32'hA3A2_A1A0, 32'hB3B2_B1B0);
    for (int k = 0; k < 8; k++) look("R6 high and low word", 64'h1_1000_0000 + 64'(k) * 1024 + 3);
    look("R2 below base", 64'h0_FFFF_FFFF);
    look("R2 last byte", 64'h1_2FFF_FFFF);
    look("R2 one past end", 64'h1_3000_0000);
    wr(2, 0, 32'h1FFF_FFFF); wr(2, 1, 32'h2); wr(2, 2, 32'h1ABC_DEF0);
    wr(2, 3, 32'h0); wr(2, 4, 32'h100); wr(2, 5, 32'h0000_005A);
    look("R1 low bits ignored base", 64'h2_1000_0000);
    look("R1 low bits ignored below", 64'h2_0FFF_FFFF);
    look("R1 low bits ignored end", 64'h2_2000_0000);
    set_dec(3, 64'h2_0000_0000, 64'h4000_0000, 32'h100, 32'h0000_00C3, 32'h0);
    look("R3 first of overlap wins", 64'h2_1800_0000);
    look("R3 later decoder when first misses", 64'h2_0800_0000);
    wr(2, 4, 32'h000); // uncommitted
    look("R4 uncommitted blocks later", 64'h2_1800_0000);
    wr(2, 4, 32'h140); // ways code 4 is illegal
    look("R5 illegal ways", 64'h2_1800_0000);
    wr(2, 4, 32'h107); // granularity code 7 is illegal
    look("R5 illegal gran", 64'h2_1800_0000);
    wr(0, 7, 32'h0);
    look("R7 only decoder 0 active", 64'h1_1000_0400);
    look("R7 decoder 0 still serves", 64'h1_0000_0100);
    wr(0, 7, 32'h2);
    wr(0, 4, 32'h126); // R10 control rewrite: gran 16 KiB, ways 4
    look("R10 new control used", 64'h1_0000_4000);
    look("R5 max granularity", 64'h1_0000_C000);

    for (int n = 0; n < 250; n++) begin
      if (n % 50 == 0) begin
        for (int d = 0; d < ND; d++) begin
          logic [31:0] c;
          c = {23'h0, ($urandom % 5) != 0, 4'($urandom % 5), 4'($urandom % 8)};
          set_dec(d, {31'h0, 1'($urandom), 4'($urandom), 28'($urandom)},
                  {32'h0, 4'($urandom), 28'($urandom)}, c, $urandom, $urandom);
        end
        wr(0, 7, 32'($urandom % 3));
      end
      look("R3 R5 R6 random", {31'h0, 33'($urandom) | 33'({$urandom % 2, 32'h0})});
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule